// File: doc/BRIEF.md
# SPI Direct-Write Window Bridge

This block turns plain bus writes into SPI byte transmissions. It needs no per-word register handshake. Each chip select has its own write window. A write to window N drives chip select N low, and its payload goes out on the serial data line.

The payload is either a full 32-bit word or a single byte. A word write sends four bytes, starting with the least significant byte, as little-endian memory order would lay them out. A byte write sends only the lowest byte of the data bus. A buffer can therefore end on a partial word. The window carries transmit data only, always as 8-bit frames in SPI mode 0. Each frame goes out most significant bit first.

The bus master holds its write request until the bridge raises `win_ready`. This happens in the cycle the last byte of the write is handed to the serial shifter, so the bus stalls while the shifter is busy. One configuration bit sets what happens to chip select between writes:
- When the bit is 0, chip select stays asserted across successive writes to the same window.
- When the bit is 1, chip select is released after each write has finished shifting. This is the reset value.

Top module: `spiwin_bridge`

## Requirements
- R1: After reset every `spi_cs_n` bit is 1, `spi_sclk` is 0 and `win_ready` is 0. The release-after-write configuration bit resets to 1.
- R2: A word write (`win_word`=1) transmits four bytes in this order: bits 7:0, 15:8, 23:16, 31:24. Each byte goes out MSB first. `spi_mosi` is valid at every rising edge of `spi_sclk` and is stable while `spi_sclk` is high.
- R3: A byte write (`win_word`=0) transmits exactly one byte, `win_data[7:0]`. The upper data bits are ignored.
- R4: A write with `win_cs`=N transmits with only `spi_cs_n[N]` low (active low). At most one chip select is low at any time.
- R5: `win_ready` is high for exactly one cycle per write. That cycle is the one in which the last byte is handed to the shifter. The master keeps `win_wr` and its data stable until then.
- R6: With the configuration bit at 0, `spi_cs_n[N]` stays low between consecutive writes to window N. It also stays low after the last of them.
- R7: With the configuration bit at 1, the selected chip select returns high once the last bit of each write has been shifted. It is high for at least one clock before the next write asserts a chip select.
- R8: With the configuration bit at 0, a write to a different window first releases the held chip select. It then asserts the new one.
- R9: A chip select never changes while a byte is being shifted. `spi_sclk` toggles only while a chip select is low.
- R10: Writing 1 to the configuration bit (`cfg_wr`=1, `cfg_release`=1) while a chip select is held releases it once the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration bit |
| cfg_release | input | 1 | Configuration bit: 1 releases chip select after each write, 0 holds it |
| win_wr | input | 1 | Window write request, held until `win_ready` |
| win_cs | input | CS_W | Window (chip select) index of the write |
| win_word | input | 1 | 1 = 32-bit write (four bytes), 0 = byte write |
| win_data | input | 32 | Write data |
| win_ready | output | 1 | Completion pulse for the current window write |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | NUM_CS | Active-low chip selects, one per window |

## Verification
The bench builds the bridge with NUM_CS = 4 and SCLK_HALF = 2. With four windows, a window switch can be exercised under both settings of the configuration bit, including the highest index. A short serial bit keeps each word to about 140 clocks, so the vector table, the hold-mode sequence and the release sequence all complete quickly. A serial-side monitor rebuilds bytes on rising `spi_sclk` and logs which chip select was low. It also counts chip-select release edges and flags any chip-select change in the middle of a byte.

// File: rtl/spiwin_pkg.sv
package spiwin_pkg;
  typedef enum logic {
    PK_IDLE = 1'b0,
    PK_SEND = 1'b1
  } pk_state_t;
endpackage

// File: rtl/spiwin_shifter.sv
module spiwin_shifter #(
  parameter int BYTE_W    = 8,
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              sclk,
  output logic              mosi
);
  localparam int DIV_W = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);
  localparam int BIT_W = (BYTE_W < 2) ? 1 : $clog2(BYTE_W);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DIV_W-1:0]  div_q, div_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    div_d  = div_q;
    if (!busy_q) begin
      if (byte_valid) begin
        busy_d = 1'b1;
        sh_d   = byte_data;
        bit_d  = '0;
        div_d  = '0;
        sclk_d = 1'b0;
      end
    end else if (div_q == DIV_W'(SCLK_HALF - 1)) begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        if (bit_q == BIT_W'(BYTE_W - 1)) begin
          busy_d = 1'b0;
        end else begin
          sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
          bit_d = bit_q + 1'b1;
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
    end
  end

  assign byte_ready = !busy_q;
  assign sclk       = sclk_q;
  assign mosi       = sh_q[BYTE_W-1];

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi)); // R2
endmodule

// File: rtl/spiwin_packer.sv
module spiwin_packer
  import spiwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_wr,
  input  logic              win_word,
  input  logic [DATA_W-1:0] win_data,
  input  logic              grant,
  output logic              start,
  output logic              idle,
  output logic              win_ready,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  input  logic              byte_ready
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  pk_state_t         st_q, st_d;
  logic [DATA_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              last_hand;

  assign start     = (st_q == PK_IDLE) && win_wr && grant;
  assign idle      = (st_q == PK_IDLE);
  assign last_hand = (st_q == PK_SEND) && byte_ready && (left_q == CNT_W'(1));

  always_comb begin
    st_d    = st_q;
    stage_d = stage_q;
    left_d  = left_q;
    if (start) begin
      st_d    = PK_SEND;
      stage_d = win_data;
      left_d  = win_word ? CNT_W'(NBYTES) : CNT_W'(1);
    end else if ((st_q == PK_SEND) && byte_ready) begin
      stage_d = {BYTE_W'(0), stage_q[DATA_W-1:BYTE_W]};
      left_d  = left_q - 1'b1;
      if (last_hand) st_d = PK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PK_IDLE;
      stage_q <= '0;
      left_q  <= '0;
    end else begin
      st_q    <= st_d;
      stage_q <= stage_d;
      left_q  <= left_d;
    end
  end

  assign byte_valid = (st_q == PK_SEND);
  assign byte_data  = stage_q[BYTE_W-1:0];
  assign win_ready  = last_hand;

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data))); // R2
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready); // R5
endmodule

// File: rtl/spiwin_cs_ctrl.sv
module spiwin_cs_ctrl #(
  parameter int NUM_CS = 8,
  parameter int CS_W   = (NUM_CS < 2) ? 1 : $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_release,
  input  logic              win_wr,
  input  logic [CS_W-1:0]   win_cs,
  input  logic              start,
  input  logic              pk_idle,
  input  logic              sh_idle,
  output logic              grant,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic            rel_q, rel_d;
  logic            on_q, on_d;
  logic [CS_W-1:0] act_q, act_d;
  logic            drop;

  assign grant = !on_q || (!rel_q && (win_cs == act_q));
  assign drop  = on_q && pk_idle && sh_idle &&
                 (rel_q || (win_wr && (win_cs != act_q)));

  always_comb begin
    rel_d = cfg_wr ? cfg_release : rel_q;
    on_d  = on_q;
    act_d = act_q;
    if (start) begin
      on_d  = 1'b1;
      act_d = win_cs;
    end else if (drop) begin
      on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b1;
      on_q  <= 1'b0;
      act_q <= '0;
    end else begin
      rel_q <= rel_d;
      on_q  <= on_d;
      act_q <= act_d;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign spi_cs_n[g] = !(on_q && (act_q == CS_W'(g)));
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R4
  AST_NO_DROP_MID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && !sh_idle) |=> on_q); // R9
  AST_RELEASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && on_q) |-> !start); // R7
endmodule

// File: rtl/spiwin_bridge.sv
module spiwin_bridge #(
  parameter int NUM_CS    = 8,
  parameter int SCLK_HALF = 4,
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int CS_W      = (NUM_CS < 2) ? 1 : $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_release,
  input  logic              win_wr,
  input  logic [CS_W-1:0]   win_cs,
  input  logic              win_word,
  input  logic [DATA_W-1:0] win_data,
  output logic              win_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic              rst_meta, rst_s;
  logic              grant, start, pk_idle;
  logic              byte_valid, byte_ready;
  logic [BYTE_W-1:0] byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  spiwin_packer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_packer (
    .clk        (clk),
    .rst_n      (rst_s),
    .win_wr     (win_wr),
    .win_word   (win_word),
    .win_data   (win_data),
    .grant      (grant),
    .start      (start),
    .idle       (pk_idle),
    .win_ready  (win_ready),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready)
  );

  spiwin_shifter #(.BYTE_W(BYTE_W), .SCLK_HALF(SCLK_HALF)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_s),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi)
  );

  spiwin_cs_ctrl #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .clk         (clk),
    .rst_n       (rst_s),
    .cfg_wr      (cfg_wr),
    .cfg_release (cfg_release),
    .win_wr      (win_wr),
    .win_cs      (win_cs),
    .start       (start),
    .pk_idle     (pk_idle),
    .sh_idle     (byte_ready),
    .grant       (grant),
    .spi_cs_n    (spi_cs_n)
  );

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_s)
    spi_sclk |-> !(&spi_cs_n)); // R9
endmodule

// File: tb/spiwin_bridge_tb.sv
`timescale 1ns/1ps
module spiwin_bridge_tb;
  localparam int NCS  = 4;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_release = 1'b0;
  logic        win_wr = 1'b0, win_word = 1'b0;
  logic [1:0]  win_cs = '0;
  logic [31:0] win_data = '0;
  logic        win_ready, spi_sclk, spi_mosi;
  logic [NCS-1:0] spi_cs_n;

  always #2.5 clk = ~clk;

  spiwin_bridge #(.NUM_CS(NCS), .SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_release(cfg_release),
    .win_wr(win_wr), .win_cs(win_cs), .win_word(win_word), .win_data(win_data),
    .win_ready(win_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n)
  );

  int total = 0, bad = 0;

  // serial-side monitor
  logic [7:0] cap_byte [256];
  int         cap_cs   [256];
  int         cap_n = 0, bitpos = 0, nocs_err = 0, midbyte_err = 0;
  int         rel_cnt [NCS];
  logic [7:0] sr = '0;
  logic [NCS-1:0] prev_cs = '1;

  initial for (int i = 0; i < NCS; i++) rel_cnt[i] = 0;

  function automatic int low_cs();
    int r = -1;
    for (int i = 0; i < NCS; i++) if (spi_cs_n[i] === 1'b0) r = i;
    return r;
  endfunction

  always @(posedge spi_sclk) begin
    if (&spi_cs_n) nocs_err++;
    sr = {sr[6:0], spi_mosi};
    bitpos++;
    if (bitpos == 8) begin
      cap_byte[cap_n] = sr;
      cap_cs[cap_n]   = low_cs();
      cap_n++;
      bitpos = 0;
    end
  end

  always @(spi_cs_n) begin
    for (int i = 0; i < NCS; i++)
      if (prev_cs[i] === 1'b0 && spi_cs_n[i] === 1'b1) rel_cnt[i]++;
    if (bitpos != 0) midbyte_err++;
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int cs, input bit word, input logic [31:0] d,
                          output int rdy);
    bit done = 0;
    rdy = 0;
    @(negedge clk);
    win_wr = 1'b1; win_cs = 2'(cs); win_word = word; win_data = d;
    while (!done) begin
      @(negedge clk);
      if (win_ready) begin rdy++; done = 1; end
    end
    @(posedge clk);
    #1 win_wr = 1'b0; win_data = 32'hx5x5x5x5;
    @(negedge clk);
    if (win_ready) rdy++;
  endtask

  task automatic cfg_write(input bit v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_release = v;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic wait_bytes(input int target);
    while (cap_n < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // {cs[1:0], word, data[31:0]}
  localparam logic [34:0] VEC [8] = '{
    {2'd0, 1'b1, 32'h11223344},
    {2'd3, 1'b0, 32'hFFFFFFA5},
    {2'd1, 1'b1, 32'h80000001},
    {2'd2, 1'b0, 32'h0000003C},
    {2'd2, 1'b1, 32'hDEADBEEF},
    {2'd0, 1'b0, 32'h12345600},
    {2'd3, 1'b1, 32'hFFFFFFFF},
    {2'd1, 1'b1, 32'h00000000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rdy, base, r1, r2, nb, cs;
    logic [31:0] d;
    bit word;
    logic [7:0] exp_b;

    repeat (5) @(negedge clk);
    chk(spi_cs_n == '1, "R1", "cs_n in reset", spi_cs_n, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == '1, "R1", "cs_n after reset", spi_cs_n, 4'hF);
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    chk(win_ready == 1'b0, "R1", "ready after reset", win_ready, 0);

    // table walk with the reset (release) setting
    foreach (VEC[v]) begin
      cs = int'(VEC[v][34:33]); word = VEC[v][32]; d = VEC[v][31:0];
      nb = word ? 4 : 1;
      base = cap_n; r1 = rel_cnt[cs];
      do_write(cs, word, d, rdy);
      chk(rdy == 1, "R5", "ready pulse count", rdy, 1);
      wait_bytes(base + nb);
      chk(cap_n == base + nb, word ? "R2" : "R3", "byte count", cap_n - base, nb);
      for (int k = 0; k < nb; k++) begin
        exp_b = d[8*k +: 8];
        chk(cap_byte[base+k] == exp_b, word ? "R2" : "R3", "byte value",
            cap_byte[base+k], exp_b);
        chk(cap_cs[base+k] == cs, "R4", "active chip select", cap_cs[base+k], cs);
      end
      chk(rel_cnt[cs] == r1 + 1, "R7", "release after write", rel_cnt[cs], r1 + 1);
      chk(spi_cs_n == '1, "R7", "all released", spi_cs_n, 4'hF);
    end

    // hold mode on window 1
    cfg_write(1'b0);
    base = cap_n; r1 = rel_cnt[1];
    do_write(1, 1'b1, 32'hA1B2C3D4, rdy);
    chk(rdy == 1, "R5", "ready pulse hold word", rdy, 1);
    do_write(1, 1'b0, 32'hFFFF005A, rdy);
    wait_bytes(base + 5);
    chk(cap_byte[base]   == 8'hD4, "R6", "held byte 0", cap_byte[base], 8'hD4);
    chk(cap_byte[base+3] == 8'hA1, "R6", "held byte 3", cap_byte[base+3], 8'hA1);
    chk(cap_byte[base+4] == 8'h5A, "R6", "held trailing byte", cap_byte[base+4], 8'h5A);
    chk(cap_cs[base+4] == 1, "R6", "trailing byte cs", cap_cs[base+4], 1);
    chk(rel_cnt[1] == r1, "R6", "no release between writes", rel_cnt[1], r1);
    chk(spi_cs_n == 4'b1101, "R6", "cs1 still held", spi_cs_n, 4'b1101);

    // switch window while holding
    r2 = rel_cnt[2];
    do_write(3, 1'b0, 32'h00000077, rdy);
    wait_bytes(base + 6);
    chk(rel_cnt[1] == r1 + 1, "R8", "old cs released", rel_cnt[1], r1 + 1);
    chk(cap_cs[base+5] == 3, "R8", "new cs active", cap_cs[base+5], 3);
    chk(cap_byte[base+5] == 8'h77, "R8", "switched byte", cap_byte[base+5], 8'h77);
    chk(spi_cs_n == 4'b0111, "R8", "cs3 held", spi_cs_n, 4'b0111);

    // release via configuration
    r2 = rel_cnt[3];
    cfg_write(1'b1);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == '1, "R10", "released by config", spi_cs_n, 4'hF);
    chk(rel_cnt[3] == r2 + 1, "R10", "release edge", rel_cnt[3], r2 + 1);

    chk(nocs_err == 0, "R9", "sclk without cs", nocs_err, 0);
    chk(midbyte_err == 0, "R9", "cs change mid byte", midbyte_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule